// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the host-facing control register set of a playback audio codec. A byte-wide host bus reaches four direct ports: an index pointer, a data window onto an indirect register array, a status byte carrying the interrupt flag, and a programmed-I/O data port. Software first writes the index port to select an indirect register. It then reads or writes that register through the data window. A mode bit held in the array sets whether 16 or 32 indirect registers can be reached.

The block enforces the access rules of the array:
- Changes to the sample-format byte are gated by a mode-change-enable bit or by a playback-only override.
- Some registers are read-only or reserved.
- One register accepts a single writable bit.
- A short auto-calibration sequence is reported after mode-change-enable is raised.

The playback counter outside this block uses the exported signals: enable, interrupt enable, format byte and 16-bit base count. When a period completes, the counter pulses a request that sets the interrupt.

The auto-calibration sequence is a two-state machine. `CAL_IDLE` moves to `CAL_ARMED` (transition *arm*) when a host write raises mode-change-enable while the calibration-select field is non-zero. `CAL_ARMED` returns to `CAL_IDLE` (transition *drain*) when the last pending read of the error-status register has been served. An *arm* seen in `CAL_ARMED` reloads the pending-read count.

Top module: `codec_ctl_regs`

## Requirements
- R1: After reset the index port reads 0x40. Indirect registers 2-5 and 18-19 read 0x88, 6-7 read 0x80, 9 reads 0x08, 12 reads 0x8A, 25-26 read 0xA0, and all others read 0x00.
- R2: A write to the index port (address 0) stores bit 7 as 0, and a read of it returns bit 7 as 0. Bit 6 of the index is mode-change-enable (MCE).
- R3: The indirect register selected through the data port (address 1) is given by index bits 3:0 when bit 6 of register 12 is clear, and by index bits 4:0 when it is set.
- R4: A write to register 8 (format) is stored whole when MCE is set. When MCE is clear and bit 4 of register 24 is set, bits 7:4 are stored and bits 3:0 keep their old value. Otherwise the write is dropped.
- R5: Writes to registers 11, 22, 27 and 29 are ignored. A write to register 12 changes only bit 6. A write to register 9 stores bit 5 as 0.
- R6: When an index write takes MCE from 0 to 1 while register 9 bits 4:3 are not both 0, the next read of register 11 returns bit 5 set. Following reads return register 11 unmodified.
- R7: Any write to the status port (address 2) clears the interrupt flag and clears bits 6:4 of register 24.
- R8: A write to register 24 that takes bit 4 from 1 to 0 clears the interrupt flag. A write that leaves bit 4 at 1 does not clear it.
- R9: A one-cycle `pb_int_set` pulse sets the interrupt flag and bit 4 of register 24 on the following edge. The pulse wins over a status-port clear in the same cycle. `int_o` equals the flag.
- R10: Reading the status port returns {7'b0, interrupt flag}. Reading address 3 returns 0x00, and writes to address 3 change nothing.
- R11: Read data is registered and is valid in the cycle after the read strobe. `play_en` is register 9 bit 0, `play_irq_en` is register 10 bit 1, `play_fmt` is register 8, and `play_count` is {register 14, register 15}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_addr | input | 2 | Direct port select: 0 index, 1 data, 2 status, 3 PIO |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| pb_int_set | input | 1 | Period-complete pulse from the playback counter |
| int_o | output | 1 | Interrupt level |
| play_en | output | 1 | Playback enable |
| play_irq_en | output | 1 | Interrupt enable for the playback counter |
| play_fmt | output | 8 | Format byte |
| play_count | output | 16 | Playback base count |

## Verification
Register writes and `pb_int_set` take effect at the first rising edge after the strobe. `int_o` and the `play_*` outputs therefore move one edge after the stimulus. Read data also appears one edge after the read strobe. The bench raises every strobe at a falling edge and drops it at the next falling edge. It samples outputs at that second falling edge, half a period after the edge that registered the result. Reads that check an earlier write are always issued after the write strobe has ended.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int R_FMT   = 8;
    localparam int R_CFG   = 9;
    localparam int R_PIN   = 10;
    localparam int R_ERR   = 11;
    localparam int R_MODE  = 12;
    localparam int R_CNTHI = 14;
    localparam int R_CNTLO = 15;
    localparam int R_RSVA  = 22;
    localparam int R_ALTST = 24;
    localparam int R_RSVB  = 27;
    localparam int R_RSVC  = 29;
    localparam logic [7:0] IDX_RESET = 8'h40;

    typedef enum logic [1:0] {
        P_INDEX = 2'd0,
        P_DATA  = 2'd1,
        P_STAT  = 2'd2,
        P_PIO   = 2'd3
    } port_e;

    typedef enum logic {
        CAL_IDLE  = 1'b0,
        CAL_ARMED = 1'b1
    } cal_state_e;

    function automatic logic [7:0] reg_reset(input int i);
        if ((i >= 2 && i <= 5) || i == 18 || i == 19) return 8'h88;
        if (i == 6 || i == 7) return 8'h80;
        if (i == R_CFG) return 8'h08;
        if (i == R_MODE) return 8'h8A;
        if (i == 25 || i == 26) return 8'hA0;
        return 8'h00;
    endfunction
endpackage

// File: rtl/cr_index_port.sv
module cr_index_port
    import codec_reg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q,
    output logic       mce,
    output logic       mce_rise
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= IDX_RESET;
        else if (wr_en)
            idx_q <= {1'b0, wdata[6:0]};
    end

    assign mce      = idx_q[6];
    assign mce_rise = wr_en && !idx_q[6] && wdata[6];
endmodule

// File: rtl/cr_autocal.sv
module cr_autocal
    import codec_reg_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rd_err,
    output logic busy
);
    localparam int CNT_W = $clog2(CAL_READS + 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAL_IDLE: begin
                if (arm) begin
                    state_d = CAL_ARMED;
                    cnt_d   = CNT_W'(CAL_READS);
                end
            end
            CAL_ARMED: begin
                if (arm) begin
                    cnt_d = CNT_W'(CAL_READS);
                end else if (rd_err) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1))
                        state_d = CAL_IDLE;
                end
            end
            default: state_d = CAL_IDLE;
        endcase
    end

    assign busy = (state_q == CAL_ARMED);
endmodule

// File: rtl/cr_indirect_file.sv
module cr_indirect_file
    import codec_reg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [RIDX_W-1:0]          idx,
    input  logic [7:0]                 wdata,
    input  logic                       mce,
    input  logic                       stat_clr,
    input  logic                       pi_set,
    output logic [NREG-1:0][7:0]       regs_o,
    output logic                       int_clr
);
    logic [7:0] cur;
    logic [7:0] wr_val;
    logic       wr_ok;

    assign cur = regs_o[idx];

    always_comb begin
        wr_val = wdata;
        wr_ok  = 1'b1;
        case (int'(idx))
            R_FMT: begin
                if (mce)
                    wr_val = wdata;
                else if (regs_o[R_ALTST][4])
                    wr_val = {wdata[7:4], cur[3:0]};
                else
                    wr_ok = 1'b0;
            end
            R_CFG:  wr_val = wdata & 8'hDF;
            R_MODE: wr_val = {cur[7], wdata[6], cur[5:0]};
            R_ERR, R_RSVA, R_RSVB, R_RSVC: wr_ok = 1'b0;
            default: wr_val = wdata;
        endcase
    end

    assign int_clr = wr_en && (int'(idx) == R_ALTST) && regs_o[R_ALTST][4] && !wdata[4];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [7:0] q;
        logic       hit;
        assign hit = wr_en && wr_ok && (int'(idx) == i);

        if (i == R_ALTST) begin : g_alt
            logic [7:0] base;
            always_comb begin
                if (hit)
                    base = wr_val;
                else if (stat_clr)
                    base = q & 8'h8F;
                else
                    base = q;
                if (pi_set)
                    base = base | 8'h10;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) q <= reg_reset(i);
                else        q <= base;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= reg_reset(i);
                else if (hit) q <= wr_val;
            end
        end

        assign regs_o[i] = q;
    end
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import codec_reg_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        pb_int_set,
    output logic        int_o,
    output logic        play_en,
    output logic        play_irq_en,
    output logic [7:0]  play_fmt,
    output logic [15:0] play_count
);
    logic [7:0]            idx_q;
    logic                  mce, mce_rise;
    logic [NREG-1:0][7:0]  regs;
    logic [RIDX_W-1:0]     idx;
    logic                  int_clr, cal_busy, stat_clr, int_q;
    logic                  wr_idx, wr_dat, rd_err;

    assign wr_idx   = host_wr && (host_addr == P_INDEX);
    assign wr_dat   = host_wr && (host_addr == P_DATA);
    assign stat_clr = host_wr && (host_addr == P_STAT);
    assign idx      = regs[R_MODE][6] ? idx_q[RIDX_W-1:0]
                                      : {1'b0, idx_q[RIDX_W-2:0]};
    assign rd_err   = host_rd && (host_addr == P_DATA) && (int'(idx) == R_ERR);

    cr_index_port u_idx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_idx), .wdata(host_wdata),
        .idx_q(idx_q), .mce(mce), .mce_rise(mce_rise)
    );

    cr_autocal #(.CAL_READS(CAL_READS)) u_cal (
        .clk(clk), .rst_n(rst_n),
        .arm(mce_rise && (regs[R_CFG][4:3] != 2'b00)),
        .rd_err(rd_err), .busy(cal_busy)
    );

    cr_indirect_file u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_dat), .idx(idx),
        .wdata(host_wdata), .mce(mce), .stat_clr(stat_clr),
        .pi_set(pb_int_set), .regs_o(regs), .int_clr(int_clr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            int_q <= 1'b0;
        else if (pb_int_set)
            int_q <= 1'b1;
        else if (stat_clr || int_clr)
            int_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= 8'h00;
        else if (host_rd) begin
            unique case (host_addr)
                P_INDEX: host_rdata <= idx_q & 8'h7F;
                P_DATA:  host_rdata <= rd_err ? (regs[R_ERR] | {2'b00, cal_busy, 5'b0})
                                              : regs[idx];
                P_STAT:  host_rdata <= {7'b0, int_q};
                P_PIO:   host_rdata <= 8'h00;
                default: host_rdata <= 8'h00;
            endcase
        end
    end

    assign int_o       = int_q;
    assign play_en     = regs[R_CFG][0];
    assign play_irq_en = regs[R_PIN][1];
    assign play_fmt    = regs[R_FMT];
    assign play_count  = {regs[R_CNTHI], regs[R_CNTLO]};
endmodule

// File: rtl/codec_ctl_regs_chk.sv
module codec_ctl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [1:0]  host_addr,
    input logic [7:0]  host_rdata,
    input logic        pb_int_set,
    input logic        int_o,
    input logic [7:0]  play_fmt
);
    AST_IDX_RD_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 2'd0 |=> !host_rdata[7]); // R2
    AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == 2'd2 && !pb_int_set |=> !int_o); // R7
    AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pb_int_set |=> int_o); // R9
    AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_o) |-> $past(pb_int_set)); // R9
    AST_STAT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 2'd2 |=> host_rdata == {7'b0, $past(int_o)}); // R10
    AST_PIO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 2'd3 |=> host_rdata == 8'h00); // R10
    AST_PIO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == 2'd3 |=> $stable(play_fmt)); // R10
endmodule

bind codec_ctl_regs codec_ctl_regs_chk u_chk (.*);

// File: tb/sim_codec_ctl_regs.sv
module sim_codec_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, pb_int_set = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        int_o, play_en, play_irq_en;
    logic [7:0]  play_fmt;
    logic [15:0] play_count;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    codec_ctl_regs u0 (.*);

    // {req[3:0], op[1:0] (0 write, 1 read-check), addr[1:0], data}
    localparam int NV = 57;
    localparam logic [15:0] VEC [NV] = '{
        {4'd1, 2'd1, 2'd0, 8'h40}, // R1 index reset
        {4'd0, 2'd0, 2'd0, 8'h0C},
        {4'd1, 2'd1, 2'd1, 8'h8A}, // R1
        {4'd0, 2'd0, 2'd0, 8'h02},
        {4'd1, 2'd1, 2'd1, 8'h88}, // R1
        {4'd0, 2'd0, 2'd0, 8'h09},
        {4'd1, 2'd1, 2'd1, 8'h08}, // R1
        {4'd0, 2'd0, 2'd1, 8'hFF},
        {4'd5, 2'd1, 2'd1, 8'hDF}, // R5 bit5 forced 0
        {4'd0, 2'd0, 2'd0, 8'hFF},
        {4'd2, 2'd1, 2'd0, 8'h7F}, // R2
        {4'd0, 2'd0, 2'd0, 8'h0B},
        {4'd6, 2'd1, 2'd1, 8'h20}, // R6 calibrating
        {4'd6, 2'd1, 2'd1, 8'h00}, // R6 drained
        {4'd0, 2'd0, 2'd1, 8'h55},
        {4'd5, 2'd1, 2'd1, 8'h00}, // R5 read-only
        {4'd0, 2'd0, 2'd0, 8'h09},
        {4'd0, 2'd0, 2'd1, 8'h01},
        {4'd0, 2'd0, 2'd0, 8'h08},
        {4'd0, 2'd0, 2'd1, 8'h3C},
        {4'd4, 2'd1, 2'd1, 8'h00}, // R4 dropped
        {4'd0, 2'd0, 2'd0, 8'h48},
        {4'd0, 2'd0, 2'd1, 8'h3C},
        {4'd4, 2'd1, 2'd1, 8'h3C}, // R4 MCE write
        {4'd0, 2'd0, 2'd0, 8'h08},
        {4'd0, 2'd0, 2'd1, 8'hA5},
        {4'd4, 2'd1, 2'd1, 8'h3C}, // R4 dropped again
        {4'd0, 2'd0, 2'd0, 8'h0C},
        {4'd0, 2'd0, 2'd1, 8'hFF},
        {4'd5, 2'd1, 2'd1, 8'hCA}, // R5 only bit6
        {4'd0, 2'd0, 2'd0, 8'h18},
        {4'd0, 2'd0, 2'd1, 8'h10},
        {4'd4, 2'd1, 2'd1, 8'h10}, // R4 override set
        {4'd0, 2'd0, 2'd0, 8'h08},
        {4'd0, 2'd0, 2'd1, 8'hA5},
        {4'd4, 2'd1, 2'd1, 8'hAC}, // R4 low nibble kept
        {4'd0, 2'd0, 2'd0, 8'h19},
        {4'd1, 2'd1, 2'd1, 8'hA0}, // R1 reg25
        {4'd0, 2'd0, 2'd0, 8'h13},
        {4'd1, 2'd1, 2'd1, 8'h88}, // R1 reg19
        {4'd0, 2'd0, 2'd0, 8'h1A},
        {4'd1, 2'd1, 2'd1, 8'hA0}, // R1 reg26
        {4'd0, 2'd0, 2'd0, 8'h1D},
        {4'd0, 2'd0, 2'd1, 8'h77},
        {4'd5, 2'd1, 2'd1, 8'h00}, // R5 reserved 29
        {4'd0, 2'd0, 2'd0, 8'h16},
        {4'd0, 2'd0, 2'd1, 8'h11},
        {4'd5, 2'd1, 2'd1, 8'h00}, // R5 reserved 22
        {4'd0, 2'd0, 2'd0, 8'h0C},
        {4'd0, 2'd0, 2'd1, 8'h00},
        {4'd3, 2'd1, 2'd1, 8'h8A}, // R3 narrow mode back
        {4'd0, 2'd0, 2'd0, 8'h19},
        {4'd3, 2'd1, 2'd1, 8'h01}, // R3 0x19 aliases reg9
        {4'd10, 2'd1, 2'd3, 8'h00}, // R10
        {4'd0, 2'd0, 2'd3, 8'hFF},
        {4'd10, 2'd1, 2'd3, 8'h00}, // R10
        {4'd10, 2'd1, 2'd2, 8'h00}  // R10
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        chk(req, {8'h0, host_rdata}, {8'h0, e});
    endtask

    task automatic pulse_pi();
        @(negedge clk);
        pb_int_set = 1'b1;
        @(negedge clk);
        pb_int_set = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {15'h0, int_o}, 16'h0);
        chk("R11", {play_en, play_irq_en, play_fmt}, 10'h0);
        chk("R11", play_count, 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][11:10] == 2'd0)
                do_wr(VEC[i][9:8], VEC[i][7:0]);
            else
                do_rd(VEC[i][9:8], VEC[i][7:0], $sformatf("R%0d", VEC[i][15:12]));
        end

        // R11 exported configuration
        chk("R11", {15'h0, play_en}, 16'h1);
        chk("R11", {8'h0, play_fmt}, 16'h00AC);
        do_wr(2'd0, 8'h0A); do_wr(2'd1, 8'h02);
        do_wr(2'd0, 8'h0E); do_wr(2'd1, 8'h12);
        do_wr(2'd0, 8'h0F); do_wr(2'd1, 8'h34);
        chk("R11", {15'h0, play_irq_en}, 16'h1);
        chk("R11", play_count, 16'h1234);

        // wide mode, point at register 24
        do_wr(2'd0, 8'h0C); do_wr(2'd1, 8'h40);
        do_wr(2'd0, 8'h18);
        do_rd(2'd1, 8'h10, "R4");

        pulse_pi();
        chk("R9", {15'h0, int_o}, 16'h1);
        do_rd(2'd2, 8'h01, "R10");
        do_wr(2'd1, 8'h70);
        chk("R8", {15'h0, int_o}, 16'h1);
        do_wr(2'd2, 8'h00);
        chk("R7", {15'h0, int_o}, 16'h0);
        do_rd(2'd1, 8'h00, "R7");

        pulse_pi();
        chk("R9", {15'h0, int_o}, 16'h1);
        do_rd(2'd1, 8'h10, "R9");
        do_wr(2'd1, 8'h00);
        chk("R8", {15'h0, int_o}, 16'h0);

        // simultaneous set and status clear
        @(negedge clk);
        pb_int_set = 1'b1; host_wr = 1'b1; host_addr = 2'd2; host_wdata = 8'h00;
        @(negedge clk);
        pb_int_set = 1'b0; host_wr = 1'b0;
        chk("R9", {15'h0, int_o}, 16'h1);
        do_wr(2'd2, 8'h00);
        chk("R7", {15'h0, int_o}, 16'h0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule